// File: doc/BRIEF.md
# Register-Fed Four-Bit ALU Datapath

This block is a small arithmetic datapath. Two operand registers are each loaded from their own data input whenever their own write enable is high. The contents of these two registers go straight into a combinational ALU. A two-bit operation code makes the ALU perform a bitwise AND, a bitwise OR, an addition or a subtraction. The ALU result and its carry go into a third register, which has its own write enable. The operand registers and the result register all update on the same edge of a single clock.

Every storage element updates on the falling clock edge. No separate input inverts the second operand: the operation code alone selects subtraction. The block computes subtraction as A plus the inverse of B plus one. Results wrap modulo 2^W, and the carry bit is the only sign of an overflow or a borrow. An active-low reset clears all storage asynchronously.

Top module: `regfed_alu`

## Requirements
- R1: While rst_n is low, a_q, b_q, r_q and c_q are all 0.
- R2: On a falling clock edge, a_q takes a_din if a_we is 1 and b_q takes b_din if b_we is 1. A register whose enable is 0 keeps its value.
- R3: With op = 2'b00, the next enabled capture stores a_q AND b_q in r_q and 0 in c_q.
- R4: With op = 2'b01, the next enabled capture stores a_q OR b_q in r_q and 0 in c_q.
- R5: With op = 2'b10, the next enabled capture stores (a_q + b_q) mod 16 in r_q and bit 4 of the full sum in c_q.
- R6: With op = 2'b11, the next enabled capture stores (a_q - b_q) mod 16 in r_q. c_q becomes 1 when a_q >= b_q (no borrow) and 0 otherwise.
- R7: r_q and c_q change only on a falling edge where r_we is 1. When r_we is 0 they keep their values, whatever op and the operand registers are doing.
- R8: If an operand register loads on the same falling edge where the result register captures, the captured result is computed from the operand values held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all storage updates on its falling edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| op | input | 2 | Operation code: 00 AND, 01 OR, 10 add, 11 subtract |
| a_we | input | 1 | Write enable of operand register A |
| a_din | input | 4 | Data input of operand register A |
| b_we | input | 1 | Write enable of operand register B |
| b_din | input | 4 | Data input of operand register B |
| r_we | input | 1 | Write enable of the result register and carry flag |
| a_q | output | 4 | Contents of operand register A |
| b_q | output | 4 | Contents of operand register B |
| r_q | output | 4 | Contents of the result register |
| c_q | output | 1 | Captured carry flag |

## Verification
An operand load and a result capture can fall on the same falling edge. The result register must then take the ALU output computed from the old operands, not the new ones. The bench provokes this by raising a_we, b_we and r_we together with fresh data inputs. It checks that r_q and c_q match the operation applied to the previous operand contents, while a_q and b_q show the new data. This same-edge case is repeated for every operation. The operand pairs are also swept exhaustively, so every carry and borrow boundary is covered.

// File: rtl/regfed_alu_pkg.sv
package regfed_alu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } alu_op_e;
endpackage

// File: rtl/nib_reg.sv
module nib_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (we) q_next = d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  // R2 R7
  property p_load;
    @(negedge clk) disable iff (!rst_n) we |=> (q == $past(d));
  endproperty
  load_chk: assert property (p_load);

  // R2 R7
  property p_hold;
    @(negedge clk) disable iff (!rst_n) !we |=> $stable(q);
  endproperty
  hold_chk: assert property (p_hold);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import regfed_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         cout
);
  logic         sub;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic [W:0]   cy;

  assign sub   = (op == OP_SUB);
  assign b_eff = b ^ {W{sub}};
  assign cy[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
  end

  always_comb begin
    unique case (op)
      OP_AND:  begin res = a & b; cout = 1'b0;  end
      OP_OR:   begin res = a | b; cout = 1'b0;  end
      default: begin res = sum;   cout = cy[W]; end
    endcase
  end
endmodule

// File: rtl/regfed_alu.sv
module regfed_alu
  import regfed_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   op,
  input  logic         a_we,
  input  logic [W-1:0] a_din,
  input  logic         b_we,
  input  logic [W-1:0] b_din,
  input  logic         r_we,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic [W-1:0] r_q,
  output logic         c_q
);
  localparam int RW = W + 1;

  alu_op_e      op_e;
  logic [W-1:0] alu_res;
  logic         alu_cout;
  logic [RW-1:0] res_q;

  assign op_e = alu_op_e'(op);

  nib_reg #(.W(W)) u_reg_a (.clk(clk), .rst_n(rst_n), .we(a_we), .d(a_din), .q(a_q));
  nib_reg #(.W(W)) u_reg_b (.clk(clk), .rst_n(rst_n), .we(b_we), .d(b_din), .q(b_q));

  alu_core #(.W(W)) u_alu (.a(a_q), .b(b_q), .op(op_e), .res(alu_res), .cout(alu_cout));

  nib_reg #(.W(RW)) u_reg_r (.clk(clk), .rst_n(rst_n), .we(r_we),
                             .d({alu_cout, alu_res}), .q(res_q));

  assign r_q = res_q[W-1:0];
  assign c_q = res_q[W];

  // R5
  property p_add;
    @(negedge clk) disable iff (!rst_n)
      (op_e == OP_ADD) |-> ({alu_cout, alu_res} == ({1'b0, a_q} + {1'b0, b_q}));
  endproperty
  add_sum_chk: assert property (p_add);

  // R6
  property p_sub;
    @(negedge clk) disable iff (!rst_n)
      (op_e == OP_SUB) |-> ((alu_res == W'(a_q - b_q)) && (alu_cout == (a_q >= b_q)));
  endproperty
  sub_borrow_chk: assert property (p_sub);

  // R3 R4
  property p_logic;
    @(negedge clk) disable iff (!rst_n)
      (r_we && (op_e == OP_AND || op_e == OP_OR)) |=> (c_q == 1'b0);
  endproperty
  logic_carry_chk: assert property (p_logic);

  // R8
  property p_and_old;
    @(negedge clk) disable iff (!rst_n)
      (r_we && op_e == OP_AND) |=> (r_q == ($past(a_q) & $past(b_q)));
  endproperty
  same_edge_chk: assert property (p_and_old);
endmodule

// File: tb/regfed_alu_tb.sv
module regfed_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op = 2'b00;
  logic       a_we = 1'b0, b_we = 1'b0, r_we = 1'b0;
  logic [3:0] a_din = 4'd0, b_din = 4'd0;
  logic [3:0] a_q, b_q, r_q;
  logic       c_q;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [3:0] ma = 0, mb = 0, mr = 0;
  logic       mc = 0;

  logic [12:0] exp_q[$];
  string       tag_q[$];

  regfed_alu u_dut (.clk(clk), .rst_n(rst_n), .op(op), .a_we(a_we), .a_din(a_din),
                    .b_we(b_we), .b_din(b_din), .r_we(r_we),
                    .a_q(a_q), .b_q(b_q), .r_q(r_q), .c_q(c_q));

  always #2 clk = ~clk;

  task automatic compare(input logic [12:0] exp, input string tag);
    logic [12:0] act;
    act = {a_q, b_q, c_q, r_q};
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: a/b/c/r actual %h %h %b %h expected %h %h %b %h", tag,
               act[12:9], act[8:5], act[4], act[3:0], exp[12:9], exp[8:5], exp[4], exp[3:0]);
    end
  endtask

  function automatic logic [4:0] model_alu(input logic [3:0] a, input logic [3:0] b,
                                           input logic [1:0] o);
    int s;
    case (o)
      2'b00: return {1'b0, a & b};
      2'b01: return {1'b0, a | b};
      2'b10: begin s = int'(a) + int'(b); return {s > 15, 4'(s)}; end
      default: begin s = int'(a) - int'(b); return {a >= b, 4'(s)}; end
    endcase
  endfunction

  // Driver: sets inputs half a cycle before the falling edge and queues the result.
  task automatic apply(input logic aw, input logic [3:0] ad, input logic bw,
                       input logic [3:0] bd, input logic rw, input logic [1:0] o,
                       input string tag);
    logic [4:0] f;
    @(posedge clk);
    a_we = aw; a_din = ad; b_we = bw; b_din = bd; r_we = rw; op = o;
    f = model_alu(ma, mb, o);
    if (rw) begin mc = f[4]; mr = f[3:0]; end
    if (aw) ma = ad;
    if (bw) mb = bd;
    exp_q.push_back({ma, mb, mc, mr});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares one cycle's outputs just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: outputs held clear during reset, even with enables up
    a_we = 1; a_din = 4'hF; b_we = 1; b_din = 4'hF; r_we = 1; op = 2'b10;
    repeat (3) @(posedge clk);
    #1 compare(13'd0, "R1");
    a_we = 0; b_we = 0; r_we = 0;
    @(posedge clk);
    rst_n = 1'b1;

    // R2 load and hold
    apply(1, 4'h5, 0, 4'h0, 0, 2'b00, "R2");
    apply(0, 4'h9, 1, 4'h3, 0, 2'b00, "R2");
    apply(0, 4'hE, 0, 4'hE, 0, 2'b10, "R2");
    // R3 R4 R5 R6 basic
    apply(0, 0, 0, 0, 1, 2'b00, "R3");
    apply(0, 0, 0, 0, 1, 2'b01, "R4");
    apply(0, 0, 0, 0, 1, 2'b10, "R5");
    apply(0, 0, 0, 0, 1, 2'b11, "R6");
    // R5 wrap: 15 + 1
    apply(1, 4'hF, 1, 4'h1, 0, 2'b00, "R5");
    apply(0, 0, 0, 0, 1, 2'b10, "R5");
    // R6 borrow: 3 - 5, and equality 7 - 7
    apply(1, 4'h3, 1, 4'h5, 0, 2'b00, "R6");
    apply(0, 0, 0, 0, 1, 2'b11, "R6");
    apply(1, 4'h7, 1, 4'h7, 0, 2'b00, "R6");
    apply(0, 0, 0, 0, 1, 2'b11, "R6");
    // R7 hold while operands and op change
    apply(1, 4'hA, 1, 4'h6, 0, 2'b10, "R7");
    apply(0, 0, 0, 0, 0, 2'b01, "R7");
    // R8 same-edge load and capture, each op
    for (int o = 0; o < 4; o++) begin
      apply(1, 4'(o * 5 + 2), 1, 4'(15 - o * 3), 1, 2'(o), "R8");
      apply(0, 0, 0, 0, 1, 2'(o), "R8");
    end
    // Exhaustive sweep of operand pairs and ops
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply(1, 4'(a), 1, 4'(b), 0, 2'b00, "R2");
        apply(0, 0, 0, 0, 1, 2'b00, "R3");
        apply(0, 0, 0, 0, 1, 2'b01, "R4");
        apply(0, 0, 0, 0, 1, 2'b10, "R5");
        apply(0, 0, 0, 0, 1, 2'b11, "R6");
      end
    end
    apply(0, 0, 0, 0, 0, 2'b00, "R7");
    repeat (2) @(posedge clk);

    // R1 mid-run reset clears everything
    @(posedge clk);
    rst_n = 1'b0;
    #1 compare(13'd0, "R1");
    @(posedge clk);
    rst_n = 1'b1;
    ma = 0; mb = 0; mr = 0; mc = 0;
    apply(0, 0, 0, 0, 0, 2'b10, "R1");
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule